// File: doc/BRIEF.md
# Packed Pixel RAM Accessor

This block sits between a requester and a byte-wide, single-port synchronous RAM. It offers two views of the same storage. The linear view reads and writes whole bytes. The bitmap view treats every 2-bit or 4-bit pixel as a separate address. A bitmap read returns one pixel, right-aligned. A bitmap write changes that one pixel inside its byte by reading the byte and writing it back merged.

A small configuration port holds three settings:
- the pixel format (2-bit or 4-bit);
- the bank of the coprocessor's 8 KB window;
- whether that window uses the linear view or the bitmap view.

A request comes in one of three kinds:
- a window access, which takes a 13-bit offset inside the selected bank;
- a direct bitmap access, which takes a 20-bit pixel index;
- a direct linear access, which takes a byte address.

The block takes a request only while it is not busy. A read answers with a one-cycle response pulse. Address decoding of the surrounding bus is out of scope, and so is the processor itself.

Top module: `pxa_packed_ram`

## Requirements
- R1: After reset `busy`, `rsp_valid` and `ram_en` are 0. The pixel format is 4-bit. The window is in linear view with bank 0.
- R2: A linear access moves a whole byte. The RAM byte address is the low `RAM_AW` bits of `req_addr`, so higher address bits wrap.
- R3: Writing configuration offset 0x3F with bit 7 = 1 selects 2-bit pixels. Pixel n then lives in byte n>>2 at bits [2*(n%4)+1 : 2*(n%4)].
- R4: Writing offset 0x3F with bit 7 = 0 selects 4-bit pixels. Pixel n then lives in byte n>>1. An even n uses bits 3:0 and an odd n uses bits 7:4.
- R5: A bitmap read returns the pixel in the low bits of `rsp_rdata`. All upper bits are zero.
- R6: A bitmap write replaces only the selected pixel, using the low bits of `req_wdata`. The other bits of the byte are kept. It uses exactly two RAM cycles: a read, then a write to the same byte.
- R7: Writing offset 0x25 sets the window. Bit 7 selects the view (1 = bitmap, 0 = linear) and bits 6:0 select the bank. A window access with offset o uses index {bank, o[12:0]}, in that view.
- R8: A direct bitmap request (`req_window` = 0, `req_bitmap` = 1) uses all 20 bits of `req_addr` as the pixel index.
- R9: `busy` is high from the cycle after a request is accepted until that request ends. A request presented while `busy` is high is dropped and has no effect.
- R10: The pixel format is sampled when a request is accepted. A format write made while the request is in flight does not change that request.
- R11: `rsp_valid` pulses for one cycle. The pulse starts on the second rising edge after the edge that accepted the read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_ofs | input | 6 | Configuration offset (0x25 window, 0x3F format) |
| cfg_wdata | input | 8 | Configuration write data |
| req_valid | input | 1 | Request present; accepted when `busy` is low |
| req_window | input | 1 | Request goes through the bank window |
| req_bitmap | input | 1 | Direct request uses the bitmap view (ignored for window requests) |
| req_we | input | 1 | Request is a write |
| req_addr | input | BANK_W+WOFS_W | Byte address, pixel index or window offset |
| req_wdata | input | 8 | Write data |
| busy | output | 1 | Request in flight |
| rsp_valid | output | 1 | Read response pulse |
| rsp_rdata | output | 8 | Read response data |
| ram_en | output | 1 | RAM cycle enable |
| ram_we | output | 1 | RAM write enable |
| ram_addr | output | RAM_AW | RAM byte address |
| ram_wdata | output | 8 | RAM write data |
| ram_rdata | input | 8 | RAM read data, valid the cycle after a read cycle |

## Verification
The assertions assume that the RAM returns read data in the cycle right after a read cycle. The merge check and the read-then-write pairing depend on that timing. They also assume that `rst_n` starts low, so the state and latched fields are defined before any property is checked.

The bench RAM model keeps to the one-cycle read timing. Between requests the bench waits for `busy` to fall, except in the two directed cases that present a request or a format change on purpose while an access is in flight. Random operations also change the format and window settings only when the block is idle.

// File: rtl/pxa_pkg.sv
package pxa_pkg;
   localparam int DATA_W = 8;
   localparam int SHIFT_W = $clog2(DATA_W);
   localparam logic [5:0] CFG_WINDOW_OFS = 6'h25;
   localparam logic [5:0] CFG_FORMAT_OFS = 6'h3F;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_ISSUE = 2'd1,
      ST_DATA  = 2'd2,
      ST_MERGE = 2'd3
   } pxa_state_e;
endpackage

// File: rtl/pxa_cfg_regs.sv
module pxa_cfg_regs
   import pxa_pkg::*;
#(
   parameter int BANK_W = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [5:0]        cfg_ofs,
   input  logic [7:0]        cfg_wdata,
   output logic              win_bitmap,
   output logic [BANK_W-1:0] win_bank,
   output logic              fmt_2bit
);
   initial begin
      assert (BANK_W >= 1 && BANK_W <= 7)
         else $error("pxa_cfg_regs: BANK_W must be 1..7");
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         win_bitmap <= 1'b0;
         win_bank   <= '0;
         fmt_2bit   <= 1'b0;
      end else if (cfg_we) begin
         if (cfg_ofs == CFG_WINDOW_OFS) begin
            win_bitmap <= cfg_wdata[7];
            win_bank   <= cfg_wdata[BANK_W-1:0];
         end
         if (cfg_ofs == CFG_FORMAT_OFS) begin
            fmt_2bit <= cfg_wdata[7];
         end
      end
   end
endmodule

// File: rtl/pxa_addr_map.sv
module pxa_addr_map
   import pxa_pkg::*;
#(
   parameter int RAM_AW = 17,
   parameter int BANK_W = 7,
   parameter int WOFS_W = 13,
   localparam int IDX_W = BANK_W + WOFS_W
) (
   input  logic [IDX_W-1:0]   req_addr,
   input  logic               req_window,
   input  logic               req_bitmap,
   input  logic               win_bitmap,
   input  logic [BANK_W-1:0]  win_bank,
   input  logic               fmt_2bit,
   output logic [RAM_AW-1:0]  byte_addr,
   output logic               is_bitmap,
   output logic [SHIFT_W-1:0] shift
);
   logic [IDX_W-1:0] idx;
   logic [IDX_W-1:0] pix_byte;
   logic [IDX_W-1:0] byte_full;

   always_comb begin
      idx       = req_window ? {win_bank, req_addr[WOFS_W-1:0]} : req_addr;
      is_bitmap = req_window ? win_bitmap : req_bitmap;
      pix_byte  = fmt_2bit ? (idx >> 2) : (idx >> 1);
      byte_full = is_bitmap ? pix_byte : idx;
      byte_addr = byte_full[RAM_AW-1:0];
      if (!is_bitmap)
         shift = '0;
      else if (fmt_2bit)
         shift = {idx[1:0], 1'b0};
      else
         shift = {idx[0], 2'b00};
   end
endmodule

// File: rtl/pxa_field_unit.sv
module pxa_field_unit
   import pxa_pkg::*;
(
   input  logic [DATA_W-1:0]  rdata,
   input  logic [DATA_W-1:0]  wdata,
   input  logic [SHIFT_W-1:0] shift,
   input  logic               is_bitmap,
   input  logic               fmt_2bit,
   output logic [DATA_W-1:0]  rd_field,
   output logic [DATA_W-1:0]  merged,
   output logic [DATA_W-1:0]  fmask
);
   logic [DATA_W-1:0] fbase;
   logic [DATA_W-1:0] wshift;

   always_comb begin
      fbase    = fmt_2bit ? DATA_W'(8'h03) : DATA_W'(8'h0F);
      fmask    = is_bitmap ? (fbase << shift) : '1;
      wshift   = is_bitmap ? ((wdata & fbase) << shift) : wdata;
      rd_field = is_bitmap ? ((rdata >> shift) & fbase) : rdata;
   end

   for (genvar b = 0; b < DATA_W; b++) begin : g_merge
      assign merged[b] = fmask[b] ? wshift[b] : rdata[b];
   end
endmodule

// File: rtl/pxa_packed_ram.sv
module pxa_packed_ram
   import pxa_pkg::*;
#(
   parameter int RAM_AW = 17,
   parameter int BANK_W = 7,
   parameter int WOFS_W = 13,
   localparam int IDX_W = BANK_W + WOFS_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [5:0]        cfg_ofs,
   input  logic [7:0]        cfg_wdata,
   input  logic              req_valid,
   input  logic              req_window,
   input  logic              req_bitmap,
   input  logic              req_we,
   input  logic [IDX_W-1:0]  req_addr,
   input  logic [7:0]        req_wdata,
   output logic              busy,
   output logic              rsp_valid,
   output logic [7:0]        rsp_rdata,
   output logic              ram_en,
   output logic              ram_we,
   output logic [RAM_AW-1:0] ram_addr,
   output logic [7:0]        ram_wdata,
   input  logic [7:0]        ram_rdata
);
   initial begin
      assert (RAM_AW >= 1 && RAM_AW <= IDX_W)
         else $error("pxa_packed_ram: RAM_AW must be 1..IDX_W");
      assert (DATA_W == 8)
         else $error("pxa_packed_ram: byte-wide RAM expected");
   end

   pxa_state_e         state;
   logic               win_bitmap;
   logic [BANK_W-1:0]  win_bank;
   logic               fmt_2bit;
   logic [RAM_AW-1:0]  map_addr;
   logic               map_bitmap;
   logic [SHIFT_W-1:0] map_shift;
   logic [RAM_AW-1:0]  lat_addr;
   logic               lat_bitmap;
   logic               lat_fmt2;
   logic [SHIFT_W-1:0] lat_shift;
   logic               lat_we;
   logic [7:0]         lat_wdata;
   logic [7:0]         rd_field;
   logic [7:0]         merged;
   logic [7:0]         merge_q;
   logic [7:0]         fld_mask;
   logic               accept;

   pxa_cfg_regs #(.BANK_W(BANK_W)) u_cfg (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_ofs(cfg_ofs),
      .cfg_wdata(cfg_wdata), .win_bitmap(win_bitmap), .win_bank(win_bank),
      .fmt_2bit(fmt_2bit)
   );

   pxa_addr_map #(.RAM_AW(RAM_AW), .BANK_W(BANK_W), .WOFS_W(WOFS_W)) u_map (
      .req_addr(req_addr), .req_window(req_window), .req_bitmap(req_bitmap),
      .win_bitmap(win_bitmap), .win_bank(win_bank), .fmt_2bit(fmt_2bit),
      .byte_addr(map_addr), .is_bitmap(map_bitmap), .shift(map_shift)
   );

   pxa_field_unit u_field (
      .rdata(ram_rdata), .wdata(lat_wdata), .shift(lat_shift),
      .is_bitmap(lat_bitmap), .fmt_2bit(lat_fmt2),
      .rd_field(rd_field), .merged(merged), .fmask(fld_mask)
   );

   assign busy   = (state != ST_IDLE);
   assign accept = req_valid && !busy;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state      <= ST_IDLE;
         rsp_valid  <= 1'b0;
         rsp_rdata  <= '0;
         merge_q    <= '0;
         lat_addr   <= '0;
         lat_bitmap <= 1'b0;
         lat_fmt2   <= 1'b0;
         lat_shift  <= '0;
         lat_we     <= 1'b0;
         lat_wdata  <= '0;
      end else begin
         rsp_valid <= 1'b0;
         unique case (state)
            ST_IDLE: begin
               if (accept) begin
                  lat_addr   <= map_addr;
                  lat_bitmap <= map_bitmap;
                  lat_fmt2   <= fmt_2bit;
                  lat_shift  <= map_shift;
                  lat_we     <= req_we;
                  lat_wdata  <= req_wdata;
                  state      <= ST_ISSUE;
               end
            end
            ST_ISSUE: begin
               state <= (lat_we && !lat_bitmap) ? ST_IDLE : ST_DATA;
            end
            ST_DATA: begin
               if (lat_we) begin
                  merge_q <= merged;
                  state   <= ST_MERGE;
               end else begin
                  rsp_valid <= 1'b1;
                  rsp_rdata <= rd_field;
                  state     <= ST_IDLE;
               end
            end
            ST_MERGE: state <= ST_IDLE;
            default:  state <= ST_IDLE;
         endcase
      end
   end

   always_comb begin
      ram_en    = (state == ST_ISSUE) || (state == ST_MERGE);
      ram_we    = ((state == ST_ISSUE) && lat_we && !lat_bitmap) || (state == ST_MERGE);
      ram_addr  = lat_addr;
      ram_wdata = (state == ST_MERGE) ? merge_q : lat_wdata;
   end
endmodule

// File: rtl/pxa_packed_ram_chk.sv
module pxa_packed_ram_chk #(
   parameter int RAM_AW = 17
) (
   input logic              clk,
   input logic              rst_n,
   input logic              busy,
   input logic              ram_en,
   input logic              ram_we,
   input logic [RAM_AW-1:0] ram_addr,
   input logic [7:0]        ram_wdata,
   input logic [7:0]        ram_rdata,
   input logic              rsp_valid,
   input logic [7:0]        rsp_rdata,
   input logic [7:0]        fld_mask,
   input logic              lat_bitmap,
   input logic              lat_fmt2
);
   // R9: the RAM is left alone while no request is in flight
   a_r9_no_ram_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !ram_en);

   // R11: a response is a single-cycle pulse
   a_r11_rsp_single: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> !rsp_valid);

   // R6: a merged write goes to the byte that was read two cycles earlier
   a_r6_rmw_same_addr: assert property (@(posedge clk) disable iff (!rst_n)
      (ram_en && ram_we && $past(ram_en && !ram_we, 2)) |-> (ram_addr == $past(ram_addr, 2)));

   // R6: bits outside the pixel keep the value that was read
   a_r6_keep_other_bits: assert property (@(posedge clk) disable iff (!rst_n)
      (ram_en && ram_we && $past(ram_en && !ram_we, 2)) |->
         (((ram_wdata ^ $past(ram_rdata)) & ~fld_mask) == 8'h00));

   // R5: a 2-bit pixel read has zero upper bits
   a_r5_zero_upper_2bit: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && lat_bitmap && lat_fmt2) |-> (rsp_rdata[7:2] == 6'b0));

   // R5: a 4-bit pixel read has zero upper bits
   a_r5_zero_upper_4bit: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && lat_bitmap && !lat_fmt2) |-> (rsp_rdata[7:4] == 4'b0));
endmodule

bind pxa_packed_ram pxa_packed_ram_chk #(.RAM_AW(RAM_AW)) u_chk (.*);

// File: tb/pxa_packed_ram_tb.sv
module pxa_packed_ram_tb;
   localparam int AW = 12;
   localparam int MEMSZ = 1 << AW;

   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic          rst_n;
   logic          cfg_we;
   logic [5:0]    cfg_ofs;
   logic [7:0]    cfg_wdata;
   logic          req_valid, req_window, req_bitmap, req_we;
   logic [19:0]   req_addr;
   logic [7:0]    req_wdata;
   logic          busy, rsp_valid;
   logic [7:0]    rsp_rdata;
   logic          ram_en, ram_we;
   logic [AW-1:0] ram_addr;
   logic [7:0]    ram_wdata;
   logic [7:0]    ram_rdata;

   pxa_packed_ram #(.RAM_AW(AW)) u_dut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_ofs(cfg_ofs), .cfg_wdata(cfg_wdata),
      .req_valid(req_valid), .req_window(req_window), .req_bitmap(req_bitmap),
      .req_we(req_we), .req_addr(req_addr), .req_wdata(req_wdata),
      .busy(busy), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
      .ram_en(ram_en), .ram_we(ram_we), .ram_addr(ram_addr),
      .ram_wdata(ram_wdata), .ram_rdata(ram_rdata)
   );

   logic [7:0] ram [0:MEMSZ-1];
   logic [7:0] exp_mem [0:MEMSZ-1];

   always_ff @(posedge clk) begin
      if (ram_en) begin
         if (ram_we) ram[ram_addr] <= ram_wdata;
         else        ram_rdata <= ram[ram_addr];
      end
   end

   int n_chk = 0;
   int n_err = 0;
   int n_en = 0;
   int n_we = 0;
   bit m_f2 = 1'b0;
   bit m_wbm = 1'b0;
   logic [6:0] m_bank = '0;

   always @(negedge clk) begin
      if (ram_en) begin
         n_en++;
         if (ram_we) n_we++;
      end
   end

   task automatic chk(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_err++;
         $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic int byte_of(input bit bm, input bit f2, input logic [19:0] idx);
      logic [19:0] b;
      b = bm ? (f2 ? (idx >> 2) : (idx >> 1)) : idx;
      return int'(b) & (MEMSZ - 1);
   endfunction

   function automatic logic [7:0] m_rd(input bit bm, input bit f2, input logic [19:0] idx);
      logic [7:0] b;
      int sh;
      b = exp_mem[byte_of(bm, f2, idx)];
      if (!bm) return b;
      sh = f2 ? int'(idx[1:0]) * 2 : int'(idx[0]) * 4;
      return (b >> sh) & (f2 ? 8'h03 : 8'h0F);
   endfunction

   task automatic m_wr(input bit bm, input bit f2, input logic [19:0] idx, input logic [7:0] wd);
      int a, sh;
      logic [7:0] msk;
      a = byte_of(bm, f2, idx);
      if (!bm) begin
         exp_mem[a] = wd;
      end else begin
         sh = f2 ? int'(idx[1:0]) * 2 : int'(idx[0]) * 4;
         msk = (f2 ? 8'h03 : 8'h0F) << sh;
         exp_mem[a] = (exp_mem[a] & ~msk) | ((wd << sh) & msk);
      end
   endtask

   task automatic resolve(input bit win, input bit bm, input logic [19:0] addr,
                          output bit vb, output logic [19:0] idx);
      if (win) begin
         vb = m_wbm;
         idx = {m_bank, addr[12:0]};
      end else begin
         vb = bm;
         idx = addr;
      end
   endtask

   task automatic set_cfg(input logic [5:0] ofs, input logic [7:0] val);
      cfg_we = 1'b1; cfg_ofs = ofs; cfg_wdata = val;
      @(posedge clk); @(negedge clk);
      cfg_we = 1'b0;
      if (ofs == 6'h25) begin m_wbm = val[7]; m_bank = val[6:0]; end
      if (ofs == 6'h3F) m_f2 = val[7];
   endtask

   task automatic do_req(input bit win, input bit bm, input bit we, input logic [19:0] addr,
                         input logic [7:0] wd, output logic [7:0] rd, output int lat);
      bit vb;
      logic [19:0] idx;
      while (busy) @(negedge clk);
      resolve(win, bm, addr, vb, idx);
      req_valid = 1'b1; req_window = win; req_bitmap = bm; req_we = we;
      req_addr = addr; req_wdata = wd;
      @(posedge clk); @(negedge clk);
      req_valid = 1'b0;
      lat = 1;
      rd = 8'h00;
      if (we) begin
         m_wr(vb, m_f2, idx, wd);
         while (busy) @(negedge clk);
      end else begin
         while (!rsp_valid && lat < 10) begin @(negedge clk); lat++; end
         rd = rsp_rdata;
         @(negedge clk);
      end
   endtask

   task automatic rd_chk(input string tag, input bit win, input bit bm, input logic [19:0] addr);
      logic [7:0] rd;
      int lat;
      bit vb;
      logic [19:0] idx;
      logic [7:0] exp;
      resolve(win, bm, addr, vb, idx);
      exp = m_rd(vb, m_f2, idx);
      do_req(win, bm, 1'b0, addr, 8'h00, rd, lat);
      chk(tag, int'(rd), int'(exp));
   endtask

   task automatic wr(input bit win, input bit bm, input logic [19:0] addr, input logic [7:0] wd);
      logic [7:0] rd;
      int lat;
      do_req(win, bm, 1'b1, addr, wd, rd, lat);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      logic [7:0] rd;
      int lat;
      int e0, w0;
      void'($urandom(32'h5EED1234));
      for (int i = 0; i < MEMSZ; i++) begin ram[i] = 8'h00; exp_mem[i] = 8'h00; end
      rst_n = 1'b0; cfg_we = 1'b0; cfg_ofs = '0; cfg_wdata = '0;
      req_valid = 1'b0; req_window = 1'b0; req_bitmap = 1'b0; req_we = 1'b0;
      req_addr = '0; req_wdata = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: idle outputs after reset
      chk("R1 busy", int'(busy), 0);
      chk("R1 rsp_valid", int'(rsp_valid), 0);
      chk("R1 ram_en", int'(ram_en), 0);

      // R1/R4: default format is 4-bit
      wr(1'b0, 1'b0, 20'h00010, 8'hA5);
      rd_chk("R1 R4 default 4-bit even pixel", 1'b0, 1'b1, 20'h00020);
      rd_chk("R4 odd pixel high nibble", 1'b0, 1'b1, 20'h00021);

      // R2: linear wrap to RAM size
      wr(1'b0, 1'b0, 20'h12345, 8'h3C);
      rd_chk("R2 linear wrap", 1'b0, 1'b0, 20'h00345);
      chk("R2 wrapped byte", int'(exp_mem[12'h345]), 8'h3C);

      // R3: 2-bit pixels
      set_cfg(6'h3F, 8'h80);
      wr(1'b0, 1'b0, 20'h00020, 8'hE4);
      for (int k = 0; k < 4; k++) rd_chk("R3 R5 2-bit pixel", 1'b0, 1'b1, 20'h00080 + 20'(k));

      // R6: bitmap write merges, two RAM cycles
      e0 = n_en; w0 = n_we;
      wr(1'b0, 1'b1, 20'h00081, 8'hFF);
      chk("R6 ram cycles", n_en - e0, 2);
      chk("R6 ram writes", n_we - w0, 1);
      rd_chk("R6 merged byte", 1'b0, 1'b0, 20'h00020);
      chk("R6 merged expected", int'(exp_mem[12'h020]), 8'hEC);

      // R7: bitmap window in bank 1, then linear window in bank 2
      wr(1'b0, 1'b0, 20'h00801, 8'h9C);
      set_cfg(6'h25, 8'h81);
      rd_chk("R7 bitmap window", 1'b1, 1'b0, 20'h00005);
      set_cfg(6'h25, 8'h02);
      wr(1'b1, 1'b1, 20'h00010, 8'h5A);
      rd_chk("R7 linear window write", 1'b0, 1'b0, 20'h00010);
      chk("R7 window byte", int'(exp_mem[12'h010]), 8'h5A);

      // R8: full 20-bit pixel index
      wr(1'b0, 1'b1, 20'hF6005, 8'h02);
      rd_chk("R8 pixel index 20 bits", 1'b0, 1'b1, 20'hF6005);

      // R11: response latency
      do_req(1'b0, 1'b0, 1'b0, 20'h00345, 8'h00, rd, lat);
      chk("R11 latency", lat, 3);
      chk("R11 data", int'(rd), 8'h3C);

      // R9: request while busy is dropped
      wr(1'b0, 1'b0, 20'h00300, 8'h11);
      while (busy) @(negedge clk);
      req_valid = 1'b1; req_window = 1'b0; req_bitmap = 1'b1; req_we = 1'b1;
      req_addr = 20'h00400; req_wdata = 8'h01;
      @(posedge clk); @(negedge clk);
      m_wr(1'b1, m_f2, 20'h00400, 8'h01);
      req_bitmap = 1'b0; req_addr = 20'h00300; req_wdata = 8'h77;
      chk("R9 busy after accept", int'(busy), 1);
      @(negedge clk);
      req_valid = 1'b0;
      while (busy) @(negedge clk);
      rd_chk("R9 dropped write", 1'b0, 1'b0, 20'h00300);

      // R10: format change in flight does not affect the read
      set_cfg(6'h3F, 8'h00);
      req_valid = 1'b1; req_window = 1'b0; req_bitmap = 1'b1; req_we = 1'b0;
      req_addr = 20'h00021;
      @(posedge clk); @(negedge clk);
      req_valid = 1'b0;
      cfg_we = 1'b1; cfg_ofs = 6'h3F; cfg_wdata = 8'h80;
      @(posedge clk); @(negedge clk);
      cfg_we = 1'b0;
      lat = 2;
      while (!rsp_valid && lat < 10) begin @(negedge clk); lat++; end
      chk("R10 sampled format", int'(rsp_rdata), int'(m_rd(1'b1, 1'b0, 20'h00021)));
      m_f2 = 1'b1;
      @(negedge clk);

      // random mix
      for (int it = 0; it < 600; it++) begin
         int r;
         r = int'($urandom % 16);
         if (r == 0) begin
            set_cfg(6'h3F, {$urandom % 2 == 1 ? 1'b1 : 1'b0, 7'h00});
         end else if (r == 1) begin
            set_cfg(6'h25, 8'($urandom));
         end else begin
            bit win, bm, we;
            logic [19:0] a;
            win = ($urandom % 4) == 0;
            bm  = ($urandom % 2) == 1;
            we  = ($urandom % 2) == 1;
            a   = 20'($urandom);
            if (we) wr(win, bm, a, 8'($urandom));
            else begin
               bit vb;
               logic [19:0] idx;
               logic [7:0] exp;
               resolve(win, bm, a, vb, idx);
               exp = m_rd(vb, m_f2, idx);
               do_req(win, bm, 1'b0, a, 8'h00, rd, lat);
               chk(vb ? "R3 R4 R5 random bitmap read" : "R2 random linear read", int'(rd), int'(exp));
               chk("R11 random latency", lat, 3);
            end
         end
      end

      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule